// File: doc/BRIEF.md
# Circular-Core Instruction Executor

This block carries out one instruction of a two-operand battle-program machine whose memory is a ring of `CORE` cells. It does not evaluate operands. An evaluator upstream delivers the executing cell, its program counter, and the resolved A and B target addresses together with the cells found there. The executor does the data movement, the modular field arithmetic and the control decision. It issues at most one cell write to core and returns the next-PC outcome to the task scheduler.

Whether an instruction acts on whole cells or on single fields depends on the operand modes. Every conditional test looks at the B-field of the B target cell. The compare and less-than instructions do not branch; they skip the following cell. All results are registered, so they appear one cycle after `go`.

Top module: `cx_exec`

## Requirements
- R1: One cycle after a cycle with `go` high, `done` is 1 and all results are valid. In every other cycle `done` is 0. `mem_we` is never 1 while `done` is 0. Reset clears `done` and `mem_we`.
- R2: Cell layout from MSB to LSB is opcode[3:0], A-mode[1:0], B-mode[1:0], A-field[AW-1:0], B-field[AW-1:0], with AW = ceil(log2 CORE). Mode 0 means immediate. Opcodes are: 0 halt-data, 1 move, 2 add, 3 subtract, 4 jump, 5 jump-if-zero, 6 jump-if-nonzero, 7 decrement-jump, 8 compare-skip, 9 split, 10 less-than-skip. Outcome codes on `nxt_kind` are: 0 step, 1 jump, 2 skip, 3 kill, 4 fork.
- R3: Move with an immediate A-mode writes the B target cell back to `b_addr` with its B-field replaced by the A-field of `a_val`. Otherwise it writes `a_val` unchanged to `b_addr`.
- R4: Add with an immediate A-mode writes the B target with B-field = (B.b + A.a) mod CORE. Otherwise it writes A-field = (B.a + A.a) mod CORE and B-field = (B.b + A.b) mod CORE. All other bits are kept.
- R5: Subtract matches R4 but computes (B − A) mod CORE in each affected field.
- R6: Jump reports outcome jump with `nxt_pc` = `a_addr` and writes nothing.
- R7: Jump-if-zero jumps to `a_addr` when B.b is 0, and jump-if-nonzero jumps when B.b is not 0. Otherwise the outcome is step.
- R8: Decrement-jump writes B.b − 1 mod CORE into the B target. It jumps to `a_addr` when that new value is non-zero and steps otherwise.
- R9: Compare-skip tests a field when either mode is immediate: the A value's A-field (A immediate) or its B-field (B immediate only) against B.b. When neither mode is immediate it tests whole cells. On equality the outcome is skip with `nxt_pc` = (pc + 2) mod CORE.
- R10: Less-than-skip takes the same field as R9 and skips, with `nxt_pc` = (pc + 2) mod CORE, when that field is unsigned-less than B.b.
- R11: Halt-data and opcodes 11 to 15 report outcome kill and never write.
- R12: Split reports outcome fork with `nxt_pc` = (pc + 1) mod CORE and `spawn_pc` = `a_addr`.
- R13: Move, add and subtract, and any test that fails, report outcome step with `nxt_pc` = (pc + 1) mod CORE, so pc = CORE−1 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Execute the presented instruction this cycle |
| ir | input | CW | Executing cell |
| pc | input | AW | Address of the executing cell |
| a_addr | input | AW | Resolved A target address |
| b_addr | input | AW | Resolved B target address |
| a_val | input | CW | Cell at the A target |
| b_val | input | CW | Cell at the B target |
| done | output | 1 | Results valid |
| nxt_kind | output | 3 | Next-PC outcome code |
| nxt_pc | output | AW | Next program counter for the task |
| spawn_pc | output | AW | Start address of a new task on fork |
| mem_we | output | 1 | Core write strobe |
| mem_addr | output | AW | Core write address |
| mem_wdata | output | CW | Core write data |

## Verification
Decrement-jump is the one instruction where a core write and a branch decision come from the same cycle and the same decremented value. The bench sweeps B.b over every value of a seven-cell ring. B.b = 1 must write 0 and step. B.b = 0 must wrap the write to CORE−1 and jump. Each case is judged on the written cell and on the outcome and PC together.

// File: rtl/cx_pkg.sv
`timescale 1ns/1ps
package cx_pkg;

    typedef enum logic [3:0] {
        OP_DAT = 4'd0,
        OP_MOV = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd3,
        OP_JMP = 4'd4,
        OP_JMZ = 4'd5,
        OP_JMN = 4'd6,
        OP_DJN = 4'd7,
        OP_CMP = 4'd8,
        OP_SPL = 4'd9,
        OP_SLT = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        NX_STEP = 3'd0,
        NX_JUMP = 3'd1,
        NX_SKIP = 3'd2,
        NX_KILL = 3'd3,
        NX_FORK = 3'd4
    } nxt_e;

    localparam logic [1:0] MD_IMM = 2'd0;

endpackage

// File: rtl/cx_ringop.sv
`timescale 1ns/1ps
// Modular add / subtract of two ring addresses: r = (x +/- y) mod CORE
module cx_ringop #(
    parameter int CORE = 8000,
    parameter int AW   = 13
) (
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    input  logic          sub,
    output logic [AW-1:0] r
);

    localparam bit POW2 = (CORE == (1 << AW));

    generate
        if (POW2) begin : g_pow2
            // natural wrap of the AW-bit adder is the modulus
            assign r = sub ? (x - y) : (x + y);
        end else begin : g_mod
            logic [AW:0] sum_w;
            logic [AW:0] dif_w;
            always_comb begin
                sum_w = {1'b0, x} + {1'b0, y};
                dif_w = {1'b0, x} - {1'b0, y};
                if (sub) begin
                    r = dif_w[AW] ? AW'(dif_w + (AW+1)'(CORE)) : dif_w[AW-1:0];
                end else begin
                    r = (sum_w >= (AW+1)'(CORE)) ? AW'(sum_w - (AW+1)'(CORE)) : sum_w[AW-1:0];
                end
            end
            // in-range operands must give an in-range result (R4, R5)
            always_comb begin
                if (int'(x) < CORE && int'(y) < CORE) begin
                    p_ring_range_r4: assert (int'(r) < CORE);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cx_nextpc.sv
`timescale 1ns/1ps
// Next-PC outcome for one instruction, given the already evaluated tests
module cx_nextpc
    import cx_pkg::*;
#(
    parameter int CORE = 8000,
    parameter int AW   = 13
) (
    input  logic [3:0]    op,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] a_addr,
    input  logic          b_zero,
    input  logic          djn_nz,
    input  logic          cmp_eq,
    input  logic          slt_lt,
    output nxt_e          kind,
    output logic [AW-1:0] npc,
    output logic [AW-1:0] spawn
);

    logic [AW-1:0] pc_p1;
    logic [AW-1:0] pc_p2;

    cx_ringop #(.CORE(CORE), .AW(AW)) u_inc1 (
        .x(pc), .y(AW'(1)), .sub(1'b0), .r(pc_p1)
    );
    cx_ringop #(.CORE(CORE), .AW(AW)) u_inc2 (
        .x(pc_p1), .y(AW'(1)), .sub(1'b0), .r(pc_p2)
    );

    assign spawn = a_addr;

    always_comb begin
        kind = NX_STEP;
        npc  = pc_p1;
        case (op)
            OP_MOV, OP_ADD, OP_SUB: ;
            OP_JMP: begin
                kind = NX_JUMP;
                npc  = a_addr;
            end
            OP_JMZ: if (b_zero) begin
                kind = NX_JUMP;
                npc  = a_addr;
            end
            OP_JMN: if (!b_zero) begin
                kind = NX_JUMP;
                npc  = a_addr;
            end
            OP_DJN: if (djn_nz) begin
                kind = NX_JUMP;
                npc  = a_addr;
            end
            OP_CMP: if (cmp_eq) begin
                kind = NX_SKIP;
                npc  = pc_p2;
            end
            OP_SLT: if (slt_lt) begin
                kind = NX_SKIP;
                npc  = pc_p2;
            end
            OP_SPL: kind = NX_FORK;
            default: begin
                kind = NX_KILL;
                npc  = pc;
            end
        endcase
    end

endmodule

// File: rtl/cx_exec.sv
`timescale 1ns/1ps
module cx_exec
    import cx_pkg::*;
#(
    parameter  int CORE = 8000,
    localparam int AW   = $clog2(CORE),
    localparam int CW   = 8 + 2 * AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] ir,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    input  logic [CW-1:0] a_val,
    input  logic [CW-1:0] b_val,
    output logic          done,
    output logic [2:0]    nxt_kind,
    output logic [AW-1:0] nxt_pc,
    output logic [AW-1:0] spawn_pc,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [CW-1:0] mem_wdata
);

    localparam int LANES = 2;      // lane 0: A-field, lane 1: B-field
    localparam int AF_HI = 2 * AW - 1;

    typedef struct packed {
        logic          done;
        nxt_e          kind;
        logic [AW-1:0] npc;
        logic [AW-1:0] spawn;
        logic          we;
        logic [AW-1:0] waddr;
        logic [CW-1:0] wdata;
    } res_t;

    res_t res_d, res_q;

    // ---- field decode ----
    logic [3:0]    ir_op;
    logic          a_imm, b_imm;
    logic [AW-1:0] av_a, av_b, bv_a, bv_b;

    assign ir_op = ir[CW-1 -: 4];
    assign a_imm = (ir[2*AW+3 -: 2] == MD_IMM);
    assign b_imm = (ir[2*AW+1 -: 2] == MD_IMM);
    assign av_a  = a_val[AF_HI -: AW];
    assign av_b  = a_val[AW-1:0];
    assign bv_a  = b_val[AF_HI -: AW];
    assign bv_b  = b_val[AW-1:0];

    // ---- arithmetic lanes ----
    logic [AW-1:0] ln_x [LANES];
    logic [AW-1:0] ln_y [LANES];
    logic [AW-1:0] ln_r [LANES];
    logic          ln_sub [LANES];

    assign ln_x[0]   = bv_a;
    assign ln_y[0]   = av_a;
    assign ln_sub[0] = (ir_op == OP_SUB);
    assign ln_x[1]   = bv_b;
    assign ln_y[1]   = (ir_op == OP_DJN) ? AW'(1) : (a_imm ? av_a : av_b);
    assign ln_sub[1] = (ir_op == OP_SUB) || (ir_op == OP_DJN);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cx_ringop #(.CORE(CORE), .AW(AW)) u_op (
            .x(ln_x[i]), .y(ln_y[i]), .sub(ln_sub[i]), .r(ln_r[i])
        );
    end

    // ---- tests ----
    logic [AW-1:0] tst_fld;
    logic          cmp_eq, slt_lt;
    nxt_e          kind_w;
    logic [AW-1:0] npc_w, spawn_w;

    assign tst_fld = a_imm ? av_a : av_b;
    assign cmp_eq  = (a_imm || b_imm) ? (tst_fld == bv_b) : (a_val == b_val);
    assign slt_lt  = (tst_fld < bv_b);

    cx_nextpc #(.CORE(CORE), .AW(AW)) u_nextpc (
        .op(ir_op), .pc(pc), .a_addr(a_addr),
        .b_zero(bv_b == '0), .djn_nz(ln_r[1] != '0),
        .cmp_eq(cmp_eq), .slt_lt(slt_lt),
        .kind(kind_w), .npc(npc_w), .spawn(spawn_w)
    );

    // ---- next-state ----
    always_comb begin
        res_d       = res_q;
        res_d.done  = go;
        res_d.we    = 1'b0;
        if (go) begin
            res_d.kind  = kind_w;
            res_d.npc   = npc_w;
            res_d.spawn = spawn_w;
            res_d.waddr = b_addr;
            res_d.wdata = b_val;
            case (ir_op)
                OP_MOV: begin
                    res_d.we    = 1'b1;
                    res_d.wdata = a_imm ? {b_val[CW-1:AW], av_a} : a_val;
                end
                OP_ADD, OP_SUB: begin
                    res_d.we    = 1'b1;
                    res_d.wdata = {b_val[CW-1:2*AW], (a_imm ? bv_a : ln_r[0]), ln_r[1]};
                end
                OP_DJN: begin
                    res_d.we    = 1'b1;
                    res_d.wdata = {b_val[CW-1:AW], ln_r[1]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done      = res_q.done;
    assign nxt_kind  = res_q.kind;
    assign nxt_pc    = res_q.npc;
    assign spawn_pc  = res_q.spawn;
    assign mem_we    = res_q.we;
    assign mem_addr  = res_q.waddr;
    assign mem_wdata = res_q.wdata;

    // ---- assertions ----
    p_done_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);
    p_we_in_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> done);
    p_kill_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nxt_kind == NX_KILL) |-> !mem_we);
    p_write_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(b_addr)));
    p_skip_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nxt_kind == NX_SKIP) |-> (int'(nxt_pc) == (int'($past(pc)) + 2) % CORE));
    p_fork_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nxt_kind == NX_FORK) |->
            ((int'(nxt_pc) == (int'($past(pc)) + 1) % CORE) && spawn_pc == $past(a_addr)));

endmodule

// File: tb/cx_exec_bench.sv
`timescale 1ns/1ps
module cx_exec_bench;

    localparam int M  = 7;
    localparam int AW = 3;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [CW-1:0] ir = '0, a_val = '0, b_val = '0;
    logic [AW-1:0] pc = '0, a_addr = '0, b_addr = '0;
    logic          done, mem_we;
    logic [2:0]    nxt_kind;
    logic [AW-1:0] nxt_pc, spawn_pc, mem_addr;
    logic [CW-1:0] mem_wdata;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    cx_exec #(.CORE(M)) u_cx_exec (
        .clk(clk), .rst_n(rst_n), .go(go), .ir(ir), .pc(pc),
        .a_addr(a_addr), .b_addr(b_addr), .a_val(a_val), .b_val(b_val),
        .done(done), .nxt_kind(nxt_kind), .nxt_pc(nxt_pc), .spawn_pc(spawn_pc),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [CW-1:0] mk(int op, int am, int bm, int af, int bf);
        return {4'(op), 2'(am), 2'(bm), 3'(af), 3'(bf)};
    endfunction

    task automatic run(input string tag, input logic [CW-1:0] c_ir, input int p,
                       input int aa, input int ba,
                       input logic [CW-1:0] c_av, input logic [CW-1:0] c_bv);
        int op, xa, xb, ya, yb, nb, fld, e_kind, e_pc;
        bit ai, bi, e_we, ok;
        logic [CW-1:0] e_wd;
        @(negedge clk);
        ir = c_ir; pc = AW'(p); a_addr = AW'(aa); b_addr = AW'(ba);
        a_val = c_av; b_val = c_bv; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        op = int'(c_ir[13:10]);
        ai = (c_ir[9:8] == 2'd0);
        bi = (c_ir[7:6] == 2'd0);
        xa = int'(c_av[5:3]); xb = int'(c_av[2:0]);
        ya = int'(c_bv[5:3]); yb = int'(c_bv[2:0]);
        fld = ai ? xa : xb;
        e_we = 0; e_wd = c_bv; e_kind = 0; e_pc = (p + 1) % M;
        case (op)
            1: begin e_we = 1; e_wd = ai ? {c_bv[13:3], 3'(xa)} : c_av; end
            2: begin
                e_we = 1;
                e_wd = {c_bv[13:6], ai ? 3'(ya) : 3'((ya + xa) % M),
                        ai ? 3'((yb + xa) % M) : 3'((yb + xb) % M)};
            end
            3: begin
                e_we = 1;
                e_wd = {c_bv[13:6], ai ? 3'(ya) : 3'((ya - xa + M) % M),
                        ai ? 3'((yb - xa + M) % M) : 3'((yb - xb + M) % M)};
            end
            4: begin e_kind = 1; e_pc = aa; end
            5: if (yb == 0) begin e_kind = 1; e_pc = aa; end
            6: if (yb != 0) begin e_kind = 1; e_pc = aa; end
            7: begin
                nb = (yb + M - 1) % M;
                e_we = 1; e_wd = {c_bv[13:3], 3'(nb)};
                if (nb != 0) begin e_kind = 1; e_pc = aa; end
            end
            8: if ((ai || bi) ? (fld == yb) : (c_av == c_bv)) begin e_kind = 2; e_pc = (p + 2) % M; end
            9: e_kind = 4;
            10: if (fld < yb) begin e_kind = 2; e_pc = (p + 2) % M; end
            default: e_kind = 3;
        endcase
        ok = (done == 1'b1) && (int'(nxt_kind) == e_kind) &&
             (e_kind == 3 || int'(nxt_pc) == e_pc) &&
             (e_kind != 4 || int'(spawn_pc) == aa) &&
             (mem_we == e_we) &&
             (!e_we || (int'(mem_addr) == ba && mem_wdata == e_wd));
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%0d pc=%0d: got done=%0d kind=%0d pc=%0d spawn=%0d we=%0d addr=%0d wd=%h; exp kind=%0d pc=%0d spawn=%0d we=%0d addr=%0d wd=%h",
                     tag, op, p, done, nxt_kind, nxt_pc, spawn_pc, mem_we, mem_addr, mem_wdata,
                     e_kind, e_pc, aa, e_we, ba, e_wd);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got no completion, expected end of sweeps");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got done=%0d we=%0d, expected 0 0", done, mem_we);
        end
        rst_n = 1'b1;

        // R13 / R3: whole-cell move, every pc including wrap at M-1
        for (int p = 0; p < M; p++)
            run("R13", mk(1, 1, 1, 0, 0), p, (p + 2) % M, (p + 3) % M,
                mk(5, 2, 1, 4, 1), mk(0, 0, 0, 6, 6));
        // R3: immediate move copies the A-field only
        for (int x = 0; x < M; x++)
            run("R3", mk(1, 0, 1, x, 2), 3, 3, 5, mk(1, 0, 1, x, 2), mk(6, 3, 2, 5, 4));

        // R1: done drops when go is low
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle: got done=%0d we=%0d, expected 0 0", done, mem_we);
        end

        // R4 / R5: add and subtract, both A-mode classes, all field pairs
        for (int op = 2; op <= 3; op++)
            for (int ai = 0; ai < 2; ai++)
                for (int x = 0; x < M; x++)
                    for (int y = 0; y < M; y++)
                        run(op == 2 ? "R4" : "R5", mk(op, ai ? 0 : 1, 1, x, 0), 2, 4, 6,
                            ai ? mk(op, 0, 1, x, 0) : mk(0, 0, 0, x, (x + 3) % M),
                            mk(4, 1, 2, y, (2 * y + 1) % M));

        // R6: jump
        for (int a = 0; a < M; a++)
            run("R6", mk(4, 1, 0, 0, 0), 1, a, 1, mk(0, 0, 0, 0, 0), mk(4, 1, 0, 0, 0));

        // R7: zero / non-zero conditional jumps
        for (int op = 5; op <= 6; op++)
            for (int y = 0; y < M; y++)
                run("R7", mk(op, 1, 1, 2, 3), 6, 4, 2, mk(0, 0, 0, 1, 1), mk(2, 1, 1, 3, y));

        // R8: decrement-jump, write and branch from the same value
        for (int y = 0; y < M; y++)
            run("R8", mk(7, 1, 2, 1, 1), 5, 0, 3, mk(0, 0, 0, 0, 0), mk(3, 1, 2, 6, y));

        // R9: field compare, A immediate
        for (int x = 0; x < M; x++)
            for (int y = 0; y < M; y++)
                run("R9", mk(8, 0, 1, x, 0), 5, 5, 1, mk(8, 0, 1, x, 0), mk(0, 0, 0, (x + 1) % M, y));
        // R9: field compare, only B immediate (A target B-field tested)
        for (int x = 0; x < M; x++)
            run("R9", mk(8, 1, 0, 0, 3), 6, 2, 6, mk(1, 1, 1, 5, x), mk(8, 1, 0, 0, 3));
        // R9 / R2: whole-cell compare; opcode and mode bits take part
        run("R9", mk(8, 1, 1, 1, 2), 6, 0, 1, mk(3, 2, 1, 4, 5), mk(3, 2, 1, 4, 5));
        run("R9", mk(8, 1, 1, 1, 2), 5, 0, 1, mk(3, 2, 1, 4, 5), mk(2, 2, 1, 4, 5));
        run("R2", mk(8, 1, 1, 1, 2), 4, 0, 1, mk(3, 2, 1, 4, 5), mk(3, 3, 1, 4, 5));
        run("R2", mk(8, 1, 1, 1, 2), 4, 0, 1, mk(3, 2, 1, 4, 5), mk(3, 2, 2, 4, 5));

        // R10: less-than skip
        for (int x = 0; x < M; x++)
            for (int y = 0; y < M; y++)
                run("R10", mk(10, 0, 1, x, 0), 5, 5, 2, mk(10, 0, 1, x, 0), mk(0, 0, 0, 0, y));

        // R11: halt-data and undefined opcodes kill without writing
        run("R11", mk(0, 3, 3, 1, 1), 2, 3, 3, mk(0, 0, 0, 0, 0), mk(0, 0, 0, 0, 0));
        for (int op = 11; op < 16; op++)
            run("R11", mk(op, 1, 1, 1, 1), 2, 3, 4, mk(1, 1, 1, 2, 2), mk(1, 1, 1, 3, 3));

        // R12: split, including pc wrap
        for (int p = 0; p < M; p++)
            run("R12", mk(9, 1, 1, 3, 0), p, (p + 3) % M, p, mk(0, 0, 0, 0, 0), mk(9, 1, 1, 3, 0));

        finish_run();
    end

endmodule